// File: doc/BRIEF.md
# Shared Script RAM Controller

This block holds a small on-chip RAM that two agents share. The first is an internal script engine. Its instruction fetches and its data reads and writes all use one request/acknowledge port. The second is a bus slave port, through which external agents fill and inspect the RAM. Every engine access is decoded against a 4 KB window that starts at a programmable 64-bit base. A hit is served from the RAM in one cycle. A miss, or any access made while internal cycles are switched off, is passed through unchanged to an external master port.

The RAM has a single port and the engine always has priority. A slave access waits a fixed three cycles before it completes. If the engine uses the RAM during that window, the slave access is abandoned and answered with a retry. Each byte carries an even-parity bit and a written flag, and the written flags are cleared at reset. A read that touches a byte never written, or a byte whose parity does not match, sets a sticky error flag. That flag drives the gross-error interrupt.

A small register port holds the base address halves, a control word, the status word and a scratch word. The engine's code image can learn the RAM base by reading the scratch word with the expose bit set.

Top module: `script_ram_ctrl`

## Requirements
- R1: An engine request whose address bits [63:12] equal the base bits [63:12] is served internally while the disable bit is clear. eng_ack rises in the cycle after the request is first seen, mst_req stays low, and a read returns the stored bytes.
- R2: An engine request outside the window drives mst_req and the master address, data and enables in the same cycle. eng_ack and eng_rdata follow mst_ack and mst_rdata.
- R3: While control bit 0 (internal-cycle disable) is set, every engine request goes to the master port, hits included, and the RAM is not touched.
- R4: When nothing interferes, a slave access sees slv_ack exactly in its fourth cycle, after three wait cycles. A write changes only the bytes selected by slv_be, and a read returns the word in that ack cycle.
- R5: If the engine starts an internal cycle while a slave access is waiting, slv_retry pulses in the next cycle instead of slv_ack, and the slave write is not performed.
- R6: When a new slave request and an internal engine cycle start in the same cycle, the engine is served and the slave gets slv_retry in the next cycle.
- R7: A read, from either port, that enables a byte never written since reset sets status bit 7, and does so in the same cycle as its ack. Reads of written bytes leave the bit alone.
- R8: irq_gross equals status bit 7. The bit stays set until a register write to status (select 3) with data bit 7 at 1, and a new error in that same cycle wins.
- R9: Base low (select 0) and base high (select 1) form the 64-bit window base. Base-low bits [11:0] always read 0.
- R10: Select 4 returns base low while control bit 1 is set. Otherwise it returns the last value written to select 4. Select 2 returns control bits [1:0].
- R11: After reset, every acknowledge, retry, interrupt and register is 0, and every RAM byte counts as never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eng_req | input | 1 | Engine request, held until eng_ack |
| eng_we | input | 1 | Engine write |
| eng_addr | input | 64 | Engine byte address |
| eng_be | input | 4 | Engine byte enables |
| eng_wdata | input | 32 | Engine write data |
| eng_ack | output | 1 | Engine acknowledge |
| eng_rdata | output | 32 | Engine read data, valid with eng_ack |
| mst_req | output | 1 | Forwarded request to external master |
| mst_we | output | 1 | Forwarded write |
| mst_addr | output | 64 | Forwarded address |
| mst_be | output | 4 | Forwarded byte enables |
| mst_wdata | output | 32 | Forwarded write data |
| mst_ack | input | 1 | External master acknowledge |
| mst_rdata | input | 32 | External master read data |
| slv_req | input | 1 | Slave request, held until slv_ack or slv_retry |
| slv_we | input | 1 | Slave write |
| slv_addr | input | 10 | Slave word index in the RAM |
| slv_be | input | 4 | Slave byte enables |
| slv_wdata | input | 32 | Slave write data |
| slv_ack | output | 1 | Slave completion |
| slv_retry | output | 1 | Slave retry response |
| slv_rdata | output | 32 | Slave read data, valid with slv_ack |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base low, 1 base high, 2 control, 3 status, 4 scratch |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| irq_gross | output | 1 | Gross-error interrupt |

## Verification
The hardest case to reach is an engine cycle that lands in the middle of a slave wait window. It only counts if it is in the window of a write the checks can later see, so the retry can be shown to have left the RAM untouched. The bench forks a slave write and an engine hit, with the engine offset by one clock, so the engine takes the RAM in the first wait cycle. A later slave read then shows the old word. A second fork starts both requests on the same edge to reach the tie case. Reads of partly written words bring out the never-written check byte by byte.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [2:0] {
    SEL_BASE_LO = 3'd0,
    SEL_BASE_HI = 3'd1,
    SEL_CTRL    = 3'd2,
    SEL_STATUS  = 3'd3,
    SEL_SCRATCH = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RESP = 2'd2
  } slv_st_e;

  localparam int CTRL_NOINT_BIT  = 0;
  localparam int CTRL_EXPOSE_BIT = 1;
  localparam int STAT_PERR_BIT   = 7;
endpackage

// File: rtl/sram_win_dec.sv
module sram_win_dec #(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              no_int,
  output logic              hit,
  output logic              int_route
);
  assign hit       = (addr[ADDR_W-1:OFF_W] == base[ADDR_W-1:OFF_W]);
  assign int_route = hit & ~no_int;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int NB    = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NB-1:0]     be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rd_err
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [NB-1:0]     par [DEPTH];
  logic [NB-1:0]     vld [DEPTH];
  logic [NB-1:0]     wpar;
  logic [NB-1:0]     bad_b;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign wpar[b]  = ^wdata[8*b +: 8];
    assign bad_b[b] = be[b] & (~vld[idx][b] | (par[idx][b] ^ (^mem[idx][8*b +: 8])));
  end

  assign rd_err = en & ~we & (|bad_b);

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) begin
          mem[idx][8*b +: 8] <= wdata[8*b +: 8];
          par[idx][b]        <= wpar[b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int i = 0; i < DEPTH; i++) vld[i] <= '0;
    end else if (en && we) begin
      vld[idx] <= vld[idx] | be;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rdata_q <= '0;
    else if (en) rdata_q <= mem[idx];
  end

  p_write_marks_valid_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (en && we && be[0]) |=> vld[$past(idx)][0]);
endmodule

// File: rtl/sram_slv_seq.sv
module sram_slv_seq
  import sram_pkg::*;
#(
  parameter int WAITS = 3,
  localparam int CW   = (WAITS > 2) ? $clog2(WAITS) : 1
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic slv_req,
  input  logic int_go,
  output logic commit,
  output logic slv_ack,
  output logic slv_retry
);
  localparam logic [CW-1:0] LAST = CW'(WAITS - 2);

  slv_st_e       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ack_q, ack_n, rty_q, rty_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    ack_n  = 1'b0;
    rty_n  = 1'b0;
    commit = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (slv_req) begin
          if (int_go) begin
            st_n  = SQ_RESP;
            rty_n = 1'b1;
          end else begin
            st_n  = SQ_WAIT;
            cnt_n = '0;
          end
        end
      end
      SQ_WAIT: begin
        if (int_go) begin
          st_n  = SQ_RESP;
          rty_n = 1'b1;
        end else if (cnt_q == LAST) begin
          commit = 1'b1;
          st_n   = SQ_RESP;
          ack_n  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
      rty_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      ack_q <= ack_n;
      rty_q <= rty_n;
    end
  end

  assign slv_ack   = ack_q;
  assign slv_retry = rty_q;

  p_ack_retry_excl_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    !(slv_ack && slv_retry));
  p_tie_retry_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == SQ_IDLE && slv_req && int_go) |=> slv_retry);
  p_ack_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(slv_ack) |-> ($past(st_q) == SQ_WAIT && $past(cnt_q) == LAST));
endmodule

// File: rtl/script_ram_ctrl.sv
module script_ram_ctrl
  import sram_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int WAITS  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eng_req,
  input  logic                    eng_we,
  input  logic [2*REG_W-1:0]      eng_addr,
  input  logic [DATA_W/8-1:0]     eng_be,
  input  logic [DATA_W-1:0]       eng_wdata,
  output logic                    eng_ack,
  output logic [DATA_W-1:0]       eng_rdata,
  output logic                    mst_req,
  output logic                    mst_we,
  output logic [2*REG_W-1:0]      mst_addr,
  output logic [DATA_W/8-1:0]     mst_be,
  output logic [DATA_W-1:0]       mst_wdata,
  input  logic                    mst_ack,
  input  logic [DATA_W-1:0]       mst_rdata,
  input  logic                    slv_req,
  input  logic                    slv_we,
  input  logic [$clog2(DEPTH)-1:0] slv_addr,
  input  logic [DATA_W/8-1:0]     slv_be,
  input  logic [DATA_W-1:0]       slv_wdata,
  output logic                    slv_ack,
  output logic                    slv_retry,
  output logic [DATA_W-1:0]       slv_rdata,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_sel,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    irq_gross
);
  localparam int ADDR_W = 2 * REG_W;
  localparam int NB     = DATA_W / 8;
  localparam int BS_W   = $clog2(NB);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int OFF_W  = IDX_W + BS_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  // configuration registers
  logic [REG_W-1:0] base_lo_q, base_lo_n, base_hi_q, base_hi_n, scr_q, scr_n;
  logic [1:0]       ctrl_q, ctrl_n;
  logic             perr_q, perr_n;
  logic             hit, int_route, int_go, int_ack_q, commit, ram_err;
  logic             wr_lo, wr_hi, wr_ctrl, wr_stat, wr_scr, clr_perr;

  // routing
  sram_win_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .addr      (eng_addr),
    .base      ({base_hi_q, base_lo_q}),
    .no_int    (ctrl_q[CTRL_NOINT_BIT]),
    .hit       (hit),
    .int_route (int_route)
  );

  assign int_go    = eng_req & int_route & ~int_ack_q;
  assign mst_req   = eng_req & ~int_route;
  assign mst_we    = eng_we;
  assign mst_addr  = eng_addr;
  assign mst_be    = eng_be;
  assign mst_wdata = eng_wdata;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) int_ack_q <= 1'b0;
    else         int_ack_q <= int_go;
  end

  // slave sequencing
  sram_slv_seq #(.WAITS(WAITS)) u_seq (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .slv_req   (slv_req),
    .int_go    (int_go),
    .commit    (commit),
    .slv_ack   (slv_ack),
    .slv_retry (slv_retry)
  );

  // shared RAM port
  logic              ram_en, ram_we;
  logic [IDX_W-1:0]  ram_idx;
  logic [NB-1:0]     ram_be;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  always_comb begin
    ram_en = int_go | commit;
    if (int_go) begin
      ram_we    = eng_we;
      ram_idx   = eng_addr[OFF_W-1:BS_W];
      ram_be    = eng_be;
      ram_wdata = eng_wdata;
    end else begin
      ram_we    = slv_we;
      ram_idx   = slv_addr;
      ram_be    = slv_be;
      ram_wdata = slv_wdata;
    end
  end

  sram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .en      (ram_en),
    .we      (ram_we),
    .idx     (ram_idx),
    .be      (ram_be),
    .wdata   (ram_wdata),
    .rdata_q (ram_rdata),
    .rd_err  (ram_err)
  );

  assign eng_ack   = int_ack_q | (eng_req & ~int_route & mst_ack);
  assign eng_rdata = int_ack_q ? ram_rdata : mst_rdata;
  assign slv_rdata = ram_rdata;

  // register next state
  always_comb begin
    wr_lo    = reg_wr && (reg_sel_e'(reg_sel) == SEL_BASE_LO);
    wr_hi    = reg_wr && (reg_sel_e'(reg_sel) == SEL_BASE_HI);
    wr_ctrl  = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
    wr_stat  = reg_wr && (reg_sel_e'(reg_sel) == SEL_STATUS);
    wr_scr   = reg_wr && (reg_sel_e'(reg_sel) == SEL_SCRATCH);
    clr_perr = wr_stat && reg_wdata[STAT_PERR_BIT];
    base_lo_n = wr_lo   ? {reg_wdata[REG_W-1:OFF_W], {OFF_W{1'b0}}} : base_lo_q;
    base_hi_n = wr_hi   ? reg_wdata       : base_hi_q;
    ctrl_n    = wr_ctrl ? reg_wdata[1:0]  : ctrl_q;
    scr_n     = wr_scr  ? reg_wdata       : scr_q;
    perr_n    = (perr_q & ~clr_perr) | ram_err;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      ctrl_q    <= '0;
      scr_q     <= '0;
      perr_q    <= 1'b0;
    end else begin
      base_lo_q <= base_lo_n;
      base_hi_q <= base_hi_n;
      ctrl_q    <= ctrl_n;
      scr_q     <= scr_n;
      perr_q    <= perr_n;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_BASE_LO: reg_rdata = base_lo_q;
      SEL_BASE_HI: reg_rdata = base_hi_q;
      SEL_CTRL:    reg_rdata = {{(REG_W-2){1'b0}}, ctrl_q};
      SEL_STATUS:  reg_rdata = REG_W'(perr_q) << STAT_PERR_BIT;
      SEL_SCRATCH: reg_rdata = ctrl_q[CTRL_EXPOSE_BIT] ? base_lo_q : scr_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_gross = perr_q;

  p_int_ack_next_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    int_go |=> eng_ack);
  p_disable_forces_ext_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (eng_req && ctrl_q[CTRL_NOINT_BIT]) |-> (!int_go && mst_req));
  p_no_port_clash_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    !(int_go && commit));
  p_err_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    ram_err |=> irq_gross);
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_gross && !clr_perr) |=> irq_gross);
endmodule

// File: tb/tb_script_ram_ctrl.sv
module tb_script_ram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        eng_req, eng_we, eng_ack;
  logic [63:0] eng_addr, mst_addr;
  logic [3:0]  eng_be, mst_be, slv_be;
  logic [31:0] eng_wdata, eng_rdata, mst_wdata, mst_rdata, slv_wdata, slv_rdata;
  logic        mst_req, mst_we, mst_ack;
  logic        slv_req, slv_we, slv_ack, slv_retry;
  logic [9:0]  slv_addr;
  logic        reg_wr, irq_gross;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;

  script_ram_ctrl dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] bmask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // reference model
  logic [31:0] m_data [1024];
  logic [3:0]  m_val  [1024];
  logic [31:0] m_lo, m_hi, m_scr;
  logic [1:0]  m_ctrl;
  bit          m_perr, e_ack, s_ack, s_retry;
  logic [3:0]  e_mask, s_mask;
  logic [31:0] e_data, s_data;
  int          s_state, s_cnt, since_rst;
  bit          mst_seen;

  function automatic bit in_route();
    return (eng_addr[63:12] == {m_hi, m_lo[31:12]}) && !m_ctrl[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) m_val[i] = 4'h0;
      m_lo = 0; m_hi = 0; m_scr = 0; m_ctrl = 0; m_perr = 0;
      e_ack = 0; s_ack = 0; s_retry = 0; e_mask = 0; s_mask = 0;
      s_state = 0; s_cnt = 0; since_rst = 0;
    end else begin
      bit igo, err, n_sack, n_sretry;
      int ix;
      since_rst++;
      err = 0; n_sack = 0; n_sretry = 0;
      igo = eng_req && in_route() && !e_ack;
      e_mask = 0;
      if (igo) begin
        ix = int'(eng_addr[11:2]);
        if (eng_we) begin
          for (int b = 0; b < 4; b++) if (eng_be[b]) begin
            m_data[ix][8*b +: 8] = eng_wdata[8*b +: 8]; m_val[ix][b] = 1'b1;
          end
        end else begin
          e_mask = eng_be & m_val[ix];
          e_data = m_data[ix];
          if ((eng_be & ~m_val[ix]) != 0) err = 1;
        end
      end
      s_mask = 0;
      case (s_state)
        0: if (slv_req) begin
             if (igo) begin s_state = 2; n_sretry = 1; end
             else begin s_state = 1; s_cnt = 0; end
           end
        1: if (igo) begin s_state = 2; n_sretry = 1; end
           else if (s_cnt == 1) begin
             ix = int'(slv_addr);
             s_state = 2; n_sack = 1;
             if (slv_we) begin
               for (int b = 0; b < 4; b++) if (slv_be[b]) begin
                 m_data[ix][8*b +: 8] = slv_wdata[8*b +: 8]; m_val[ix][b] = 1'b1;
               end
             end else begin
               s_mask = slv_be & m_val[ix];
               s_data = m_data[ix];
               if ((slv_be & ~m_val[ix]) != 0) err = 1;
             end
           end else s_cnt++;
        default: s_state = 0;
      endcase
      if (reg_wr) begin
        case (reg_sel)
          3'd0: m_lo = {reg_wdata[31:12], 12'h000};
          3'd1: m_hi = reg_wdata;
          3'd2: m_ctrl = reg_wdata[1:0];
          3'd3: if (reg_wdata[7]) m_perr = 0;
          3'd4: m_scr = reg_wdata;
          default: ;
        endcase
      end
      if (err) m_perr = 1;
      e_ack = igo; s_ack = n_sack; s_retry = n_sretry;
    end
  end

  function automatic logic [31:0] m_reg();
    case (reg_sel)
      3'd0: return m_lo;
      3'd1: return m_hi;
      3'd2: return {30'd0, m_ctrl};
      3'd3: return {24'd0, m_perr, 7'd0};
      3'd4: return m_ctrl[1] ? m_lo : m_scr;
      default: return 32'd0;
    endcase
  endfunction

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n && since_rst >= 3 && !done) begin
      bit inr;
      inr = in_route();
      if (mst_req) mst_seen = 1;
      chk("R2 R3 mst_req", mst_req, eng_req && !inr);
      chk("R1 R2 eng_ack", eng_ack, e_ack || (eng_req && !inr && mst_ack));
      if (e_ack && e_mask != 0)
        chk("R1 eng_rdata", eng_rdata & bmask(e_mask), e_data & bmask(e_mask));
      if (!e_ack && eng_ack) chk("R2 eng_rdata", eng_rdata, mst_rdata);
      chk("R4 slv_ack", slv_ack, s_ack);
      chk("R5 R6 slv_retry", slv_retry, s_retry);
      if (s_ack && s_mask != 0)
        chk("R4 slv_rdata", slv_rdata & bmask(s_mask), s_data & bmask(s_mask));
      chk("R8 irq_gross", irq_gross, m_perr);
      chk("R9 R10 reg_rdata", reg_rdata, m_reg());
    end
  end

  // drivers
  task automatic eng_acc(input bit we, input logic [63:0] a, input logic [3:0] be,
                         input logic [31:0] d);
    @(posedge clk); #2;
    eng_req = 1; eng_we = we; eng_addr = a; eng_be = be; eng_wdata = d;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); #2;
      if (eng_ack) break;
      if (mst_req && !mst_ack) begin mst_ack = 1; mst_rdata = 32'h5EED_0000 ^ a[31:0]; end
    end
    eng_req = 0; mst_ack = 0;
  endtask

  task automatic slv_acc(input bit we, input logic [9:0] a, input logic [3:0] be,
                         input logic [31:0] d, output bit got_ack, output bit got_rty);
    got_ack = 0; got_rty = 0;
    @(posedge clk); #2;
    slv_req = 1; slv_we = we; slv_addr = a; slv_be = be; slv_wdata = d;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); #2;
      if (slv_ack || slv_retry) begin got_ack = slv_ack; got_rty = slv_retry; break; end
    end
    slv_req = 0;
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0; reg_sel = 3'd3;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [63:0] WIN = 64'h0000_0012_ABCD_E000;

  initial begin
    bit ga, gr;
    rst_n = 0; eng_req = 0; eng_we = 0; eng_addr = 0; eng_be = 0; eng_wdata = 0;
    mst_ack = 0; mst_rdata = 0; slv_req = 0; slv_we = 0; slv_addr = 0; slv_be = 0;
    slv_wdata = 0; reg_wr = 0; reg_sel = 3'd3; reg_wdata = 0; mst_seen = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (5) @(posedge clk);
    #2;
    // R11 reset state
    chk("R11 eng_ack", eng_ack, 0);
    chk("R11 slv_ack", slv_ack, 0);
    chk("R11 slv_retry", slv_retry, 0);
    chk("R11 irq", irq_gross, 0);
    for (int s = 0; s < 5; s++) begin reg_sel = 3'(s); #1 chk("R11 reg", reg_rdata, 0); end
    reg_sel = 3'd3;

    // R9 base setup, low bits masked
    reg_write(3'd0, WIN[31:0] | 32'h0000_0FFF);
    reg_write(3'd1, WIN[63:32]);
    reg_sel = 3'd0; #1 chk("R9 base_lo", reg_rdata, WIN[31:0]);
    reg_sel = 3'd3;

    // R4 slave write / read, partial bytes
    slv_acc(1, 10'd5, 4'hF, 32'h1122_3344, ga, gr); chk("R4 ack", ga, 1);
    slv_acc(1, 10'd5, 4'h2, 32'hAAAA_BBBB, ga, gr);
    slv_acc(0, 10'd5, 4'hF, 0, ga, gr); chk("R4 read ack", ga, 1);
    chk("R7 no err", irq_gross, 0);

    // R1 engine hit: write then read, no master traffic
    mst_seen = 0;
    eng_acc(1, WIN + 64'h40, 4'hF, 32'hDEAD_BEEF);
    eng_acc(0, WIN + 64'h40, 4'hF, 0);
    eng_acc(0, WIN + 64'h14, 4'hF, 0);
    chk("R1 no master", mst_seen, 0);

    // R2 miss: upper half differs, and below window
    mst_seen = 0;
    eng_acc(0, WIN ^ 64'h0001_0000_0000_0000, 4'hF, 0);
    eng_acc(1, WIN - 64'h4, 4'h3, 32'h0BAD_F00D);
    chk("R2 forwarded", mst_seen, 1);

    // R3 disable forces hits external; RAM untouched
    reg_write(3'd2, 32'h1);
    mst_seen = 0;
    eng_acc(1, WIN + 64'h40, 4'hF, 32'h0000_0000);
    chk("R3 forwarded", mst_seen, 1);
    reg_write(3'd2, 32'h0);
    eng_acc(0, WIN + 64'h40, 4'hF, 0);

    // R7/R8 unwritten read by engine, sticky, write-1-clear
    eng_acc(0, WIN + 64'h200, 4'h1, 0);
    chk("R7 irq set", irq_gross, 1);
    reg_write(3'd3, 32'h0);
    chk("R8 sticky", irq_gross, 1);
    reg_write(3'd3, 32'h80);
    chk("R8 cleared", irq_gross, 0);

    // R7 slave partial: written bytes ok, unwritten byte flags
    slv_acc(1, 10'd300, 4'h3, 32'h0000_7777, ga, gr);
    slv_acc(0, 10'd300, 4'h3, 0, ga, gr);
    chk("R7 written ok", irq_gross, 0);
    slv_acc(0, 10'd300, 4'h4, 0, ga, gr);
    chk("R7 unwritten byte", irq_gross, 1);
    reg_write(3'd3, 32'h80);

    // R5 engine hit during slave wait: retry, write dropped
    fork
      slv_acc(1, 10'd5, 4'hF, 32'h9999_9999, ga, gr);
      begin @(posedge clk); eng_acc(0, WIN + 64'h40, 4'hF, 0); end
    join
    chk("R5 retry", gr, 1);
    chk("R5 no ack", ga, 0);
    slv_acc(0, 10'd5, 4'hF, 0, ga, gr);

    // R6 same-cycle start: engine wins
    fork
      slv_acc(1, 10'd6, 4'hF, 32'h6666_6666, ga, gr);
      eng_acc(0, WIN + 64'h14, 4'hF, 0);
    join
    chk("R6 retry", gr, 1);
    slv_acc(0, 10'd6, 4'hF, 0, ga, gr);
    chk("R6 dropped write flags", irq_gross, 1);
    reg_write(3'd3, 32'h80);

    // R10 scratch and expose bit
    reg_write(3'd4, 32'h1357_9BDF);
    reg_sel = 3'd4; #1 chk("R10 scratch", reg_rdata, 32'h1357_9BDF);
    reg_write(3'd2, 32'h2);
    reg_sel = 3'd4; #1 chk("R10 expose", reg_rdata, WIN[31:0]);
    reg_sel = 3'd2; #1 chk("R10 ctrl", reg_rdata, 32'h2);
    reg_sel = 3'd3;
    eng_acc(0, WIN + 64'h40, 4'hF, 0);
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule